// File: doc/BRIEF.md
# Byte-Addressable Stack Pointer Register

This block holds the processor's 16-bit stack pointer and presents it to software as two byte-wide registers on the core's I/O bus. Either byte can be loaded or read on its own. The core also drives four single-cycle control pulses: store one data byte, fetch one data byte, store a return address, and fetch a return address. For each pulse, the block moves the pointer by one or two. It also produces the SRAM address of every byte that the stack access touches.

The pointer always names the next free stack location. A store uses the current pointer and then moves it down. A fetch moves the pointer up and then uses the new value. A two-byte operation spans two cycles. The first byte's address appears in the cycle of the pulse, and the second byte's address appears in the cycle after it.

A small state machine sequences this. It has three states: `ST_IDLE`, `ST_PUSH_TAIL` and `ST_POP_TAIL`. An accepted return-address store moves `ST_IDLE` to `ST_PUSH_TAIL`. An accepted return-address fetch moves `ST_IDLE` to `ST_POP_TAIL`. Both tail states go back to `ST_IDLE` unconditionally after one cycle. Single-byte operations, dropped operations and idle cycles keep the machine in `ST_IDLE`.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer is 0x0000, `acc_valid` is low, and both pointer bytes read back as 0x00.
- R2: The upper pointer byte sits at I/O address 0x3E and the lower byte at 0x3D. `io_rdata` returns the addressed byte combinationally. Any other address reads 0x00, and writes to it leave the pointer unchanged.
- R3: An I/O write to one byte replaces only that byte. The other byte keeps its value.
- R4: A `push_byte` pulse taken in `ST_IDLE` shows `acc_valid` with `acc_addr` equal to the current pointer in the same cycle. The pointer then decreases by 1.
- R5: A `pop_byte` pulse taken in `ST_IDLE` shows `acc_addr` equal to the pointer plus 1 in the same cycle. The pointer then increases by 1.
- R6: A `push_ret` pulse taken in `ST_IDLE` gives two accesses. The first is at the pointer P in the pulse cycle, and the second is at P-1 in the next cycle. The pointer becomes P-2.
- R7: A `pop_ret` pulse taken in `ST_IDLE` gives two accesses. The first is at P+1 in the pulse cycle, and the second is at P+2 in the next cycle. The pointer becomes P+2.
- R8: All pointer and access-address arithmetic wraps modulo 2^16.
- R9: When an I/O write to either pointer byte coincides with a stack pulse, the write is applied and the stack operation is dropped. The dropped operation causes no access and no step.
- R10: When several pulses arrive together, only one is taken. The order of precedence is `push_ret`, then `pop_ret`, then `push_byte`, then `pop_byte`.
- R11: Stack pulses that arrive while the machine is in `ST_PUSH_TAIL` or `ST_POP_TAIL` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 6 | I/O register address |
| io_wr | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for the addressed pointer byte |
| push_byte | input | 1 | Store one data byte |
| pop_byte | input | 1 | Fetch one data byte |
| push_ret | input | 1 | Store a two-byte return address |
| pop_ret | input | 1 | Fetch a two-byte return address |
| sp_out | output | 16 | Current pointer value |
| acc_valid | output | 1 | A stack byte access takes place this cycle |
| acc_addr | output | 16 | SRAM address of that access |

## Verification
The bound checker watches every cycle for the following:
- the step applied after each accepted pulse;
- the second access of a two-byte operation and the address it uses;
- byte-lane write isolation;
- the dropping of stack pulses during I/O writes and tail states;
- the precedence among simultaneous pulses.

Some behaviour can only be shown by the bench's scenarios, because it depends on exact sequences and sampled values:
- the ordered stream of access addresses, compared against a scoreboard;
- readback through the I/O port;
- wrap-around at 0x0000 and 0xFFFF;
- the absence of any access when an operation is dropped.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PUSH_B,
        OP_POP_B,
        OP_PUSH_R,
        OP_POP_R
    } sp_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH_TAIL,
        ST_POP_TAIL
    } sp_state_e;

endpackage

// File: rtl/sp_op_select.sv
module sp_op_select
    import sp_pkg::*;
(
    input  logic   push_byte,
    input  logic   pop_byte,
    input  logic   push_ret,
    input  logic   pop_ret,
    output sp_op_e op_sel
);

    // fixed precedence: return-address traffic first, then single bytes
    always_comb begin
        if (push_ret)       op_sel = OP_PUSH_R;
        else if (pop_ret)   op_sel = OP_POP_R;
        else if (push_byte) op_sel = OP_PUSH_B;
        else if (pop_byte)  op_sel = OP_POP_B;
        else                op_sel = OP_NONE;
    end

endmodule

// File: rtl/sp_io_port.sv
module sp_io_port #(
    parameter int               BW      = 8,
    parameter int               IOW     = 6,
    parameter logic [IOW-1:0]   HI_ADDR = 6'h3E,
    parameter logic [IOW-1:0]   LO_ADDR = 6'h3D,
    localparam int              AW      = 2 * BW
) (
    input  logic [IOW-1:0] io_addr,
    input  logic           io_wr,
    input  logic [AW-1:0]  sp_q,
    output logic [1:0]     wr_lane,
    output logic [BW-1:0]  io_rdata
);

    logic [BW-1:0] lane_rd [2];

    for (genvar b = 0; b < 2; b++) begin : g_lane
        localparam logic [IOW-1:0] LANE_ADDR = (b == 1) ? HI_ADDR : LO_ADDR;
        assign wr_lane[b] = io_wr && (io_addr == LANE_ADDR);
        assign lane_rd[b] = (io_addr == LANE_ADDR) ? sp_q[b*BW +: BW] : '0;
    end

    assign io_rdata = lane_rd[0] | lane_rd[1];

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import sp_pkg::*;
#(
    parameter int             BW      = 8,
    parameter int             IOW     = 6,
    parameter logic [IOW-1:0] HI_ADDR = 6'h3E,
    parameter logic [IOW-1:0] LO_ADDR = 6'h3D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IOW-1:0]    io_addr,
    input  logic              io_wr,
    input  logic [BW-1:0]     io_wdata,
    output logic [BW-1:0]     io_rdata,
    input  logic              push_byte,
    input  logic              pop_byte,
    input  logic              push_ret,
    input  logic              pop_ret,
    output logic [2*BW-1:0]   sp_out,
    output logic              acc_valid,
    output logic [2*BW-1:0]   acc_addr
);

    localparam int            AW  = 2 * BW;
    localparam logic [AW-1:0] ONE = AW'(1);
    localparam logic [AW-1:0] TWO = AW'(2);

    sp_state_e     state_q, state_d;
    logic [AW-1:0] sp_q, sp_d;
    sp_op_e        op_sel, op_ok;
    logic [1:0]    wr_lane;
    logic          io_hit;

    sp_op_select u_sel (
        .push_byte (push_byte),
        .pop_byte  (pop_byte),
        .push_ret  (push_ret),
        .pop_ret   (pop_ret),
        .op_sel    (op_sel)
    );

    sp_io_port #(
        .BW      (BW),
        .IOW     (IOW),
        .HI_ADDR (HI_ADDR),
        .LO_ADDR (LO_ADDR)
    ) u_io (
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .sp_q     (sp_q),
        .wr_lane  (wr_lane),
        .io_rdata (io_rdata)
    );

    assign io_hit = |wr_lane;
    // a stack pulse counts only in idle and when no pointer byte is being written
    assign op_ok  = (state_q == ST_IDLE && !io_hit) ? op_sel : OP_NONE;

    // state and pointer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            sp_q    <= '0;
        end else begin
            state_q <= state_d;
            sp_q    <= sp_d;
        end
    end

    // next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (op_ok == OP_PUSH_R)     state_d = ST_PUSH_TAIL;
                else if (op_ok == OP_POP_R) state_d = ST_POP_TAIL;
                else                        state_d = ST_IDLE;
            end
            ST_PUSH_TAIL: state_d = ST_IDLE;
            ST_POP_TAIL:  state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs: next pointer and access address
    always_comb begin
        sp_d      = sp_q;
        acc_valid = 1'b0;
        acc_addr  = sp_q;
        if (wr_lane[1]) sp_d[AW-1:BW] = io_wdata;
        if (wr_lane[0]) sp_d[BW-1:0]  = io_wdata;
        unique case (state_q)
            ST_IDLE: begin
                unique case (op_ok)
                    OP_PUSH_B: begin
                        acc_valid = 1'b1;
                        acc_addr  = sp_q;
                        sp_d      = sp_q - ONE;
                    end
                    OP_POP_B: begin
                        acc_valid = 1'b1;
                        acc_addr  = sp_q + ONE;
                        sp_d      = sp_q + ONE;
                    end
                    OP_PUSH_R: begin
                        acc_valid = 1'b1;
                        acc_addr  = sp_q;
                        sp_d      = sp_q - TWO;
                    end
                    OP_POP_R: begin
                        acc_valid = 1'b1;
                        acc_addr  = sp_q + ONE;
                        sp_d      = sp_q + TWO;
                    end
                    default: ;
                endcase
            end
            ST_PUSH_TAIL: begin
                // pointer already moved down by two; second byte sits just above it
                acc_valid = 1'b1;
                acc_addr  = sp_q + ONE;
            end
            ST_POP_TAIL: begin
                // pointer already moved up by two; second byte is the pointer itself
                acc_valid = 1'b1;
                acc_addr  = sp_q;
            end
            default: ;
        endcase
    end

    assign sp_out = sp_q;

endmodule

// File: rtl/sp_chk.sv
module sp_chk
    import sp_pkg::*;
#(
    parameter int             BW      = 8,
    parameter int             IOW     = 6,
    parameter logic [IOW-1:0] HI_ADDR = 6'h3E,
    parameter logic [IOW-1:0] LO_ADDR = 6'h3D,
    localparam int            AW      = 2 * BW
) (
    input logic           clk,
    input logic           rst_n,
    input logic [IOW-1:0] io_addr,
    input logic           io_wr,
    input logic [BW-1:0]  io_wdata,
    input logic           push_byte,
    input logic           pop_byte,
    input logic           push_ret,
    input logic           pop_ret,
    input logic [AW-1:0]  sp_out,
    input logic           acc_valid,
    input logic [AW-1:0]  acc_addr,
    input sp_state_e      state_q
);

    logic hi_w, lo_w, any_pulse, idle_free;
    assign hi_w      = io_wr && (io_addr == HI_ADDR);
    assign lo_w      = io_wr && (io_addr == LO_ADDR);
    assign any_pulse = push_byte || pop_byte || push_ret || pop_ret;
    assign idle_free = (state_q == ST_IDLE) && !hi_w && !lo_w;

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sp_out == '0) && (state_q == ST_IDLE));

    // R3
    hi_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_w |=> (sp_out[AW-1:BW] == $past(io_wdata)) && (sp_out[BW-1:0] == $past(sp_out[BW-1:0])));

    // R3
    lo_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_w |=> (sp_out[BW-1:0] == $past(io_wdata)) && (sp_out[AW-1:BW] == $past(sp_out[AW-1:BW])));

    // R2
    unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && !hi_w && !lo_w && !any_pulse) |=> $stable(sp_out));

    // R4
    push_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_free && push_byte && !push_ret && !pop_ret) |=> (sp_out == AW'($past(sp_out) - 1)));

    // R5
    pop_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_free && pop_byte && !push_byte && !push_ret && !pop_ret) |=> (sp_out == AW'($past(sp_out) + 1)));

    // R6
    push_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_free && push_ret) |=> acc_valid && (acc_addr == AW'($past(sp_out) - 1))
                                    && (sp_out == AW'($past(sp_out) - 2)));

    // R7
    pop_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_free && pop_ret && !push_ret) |=> acc_valid && (acc_addr == AW'($past(sp_out) + 2))
                                                && (sp_out == AW'($past(sp_out) + 2)));

    // R9
    collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((hi_w || lo_w) && (state_q == ST_IDLE)) |-> !acc_valid);

    // R10
    precedence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_free && push_ret && (pop_ret || push_byte || pop_byte)) |=> (state_q == ST_PUSH_TAIL));

    // R11
    tail_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != ST_IDLE) && !hi_w && !lo_w) |=> $stable(sp_out) && (state_q == ST_IDLE));

endmodule

bind stack_ptr_unit sp_chk #(
    .BW      (BW),
    .IOW     (IOW),
    .HI_ADDR (HI_ADDR),
    .LO_ADDR (LO_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_wdata  (io_wdata),
    .push_byte (push_byte),
    .pop_byte  (pop_byte),
    .push_ret  (push_ret),
    .pop_ret   (pop_ret),
    .sp_out    (sp_out),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .state_q   (state_q)
);

// File: tb/sim_stack_ptr_unit.sv
`timescale 1ns/1ps
module sim_stack_ptr_unit;

    localparam logic [5:0] HI = 6'h3E;
    localparam logic [5:0] LO = 6'h3D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  io_addr = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        push_byte = 1'b0, pop_byte = 1'b0, push_ret = 1'b0, pop_ret = 1'b0;
    logic [15:0] sp_out, acc_addr;
    logic        acc_valid;

    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    logic [15:0] m_sp = '0;
    logic [15:0] exp_q[$];
    string       req_q[$];
    string       mon_req;
    logic [15:0] mon_exp;

    always #5 clk = ~clk;

    stack_ptr_unit u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .push_byte(push_byte),
        .pop_byte(pop_byte), .push_ret(push_ret), .pop_ret(pop_ret),
        .sp_out(sp_out), .acc_valid(acc_valid), .acc_addr(acc_addr)
    );

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: samples just before each rising edge, compares against scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #4;
            if (rst_n && acc_valid) begin
                if (exp_q.size() == 0) begin
                    checks++;
                    errors++;
                    $display("FAIL R9/R11 unexpected access actual=%h expected=none", acc_addr);
                end else begin
                    mon_req = req_q.pop_front();
                    mon_exp = exp_q.pop_front();
                    check16(mon_req, acc_addr, mon_exp);
                end
            end
        end
    end

    task automatic expect_acc(input logic [15:0] a, input string req);
        exp_q.push_back(a);
        req_q.push_back(req);
    endtask

    task automatic io_write(input logic [5:0] a, input logic [7:0] d);
        io_addr  = a;
        io_wdata = d;
        io_wr    = 1'b1;
        if (a == HI) m_sp[15:8] = d;
        else if (a == LO) m_sp[7:0] = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [5:0] a, input logic [7:0] exp, input string req);
        io_addr = a;
        #1;
        check16(req, {8'h00, io_rdata}, {8'h00, exp});
    endtask

    // kind: 0 byte store, 1 byte fetch, 2 return store, 3 return fetch
    task automatic stack_op(input int kind, input string req);
        case (kind)
            0: begin push_byte = 1'b1; expect_acc(m_sp, req); m_sp = m_sp - 16'd1; end
            1: begin pop_byte = 1'b1; expect_acc(m_sp + 16'd1, req); m_sp = m_sp + 16'd1; end
            2: begin
                push_ret = 1'b1;
                expect_acc(m_sp, req);
                expect_acc(m_sp - 16'd1, req);
                m_sp = m_sp - 16'd2;
            end
            default: begin
                pop_ret = 1'b1;
                expect_acc(m_sp + 16'd1, req);
                expect_acc(m_sp + 16'd2, req);
                m_sp = m_sp + 16'd2;
            end
        endcase
        @(negedge clk);
        push_byte = 1'b0; pop_byte = 1'b0; push_ret = 1'b0; pop_ret = 1'b0;
        if (kind >= 2) @(negedge clk);
    endtask

    task automatic set_sp(input logic [15:0] v);
        io_write(HI, v[15:8]);
        io_write(LO, v[7:0]);
    endtask

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check16("R1", sp_out, 16'h0000);
        check16("R1", {15'd0, acc_valid}, 16'd0);
        rd_check(HI, 8'h00, "R1");
        rd_check(LO, 8'h00, "R1");

        // R2 / R3 byte access
        io_write(HI, 8'h12);
        check16("R3", sp_out, 16'h1200);
        io_write(LO, 8'h34);
        check16("R2", sp_out, 16'h1234);
        rd_check(HI, 8'h12, "R2");
        rd_check(LO, 8'h34, "R2");
        io_write(HI, 8'hAB);
        check16("R3", sp_out, 16'hAB34);
        io_write(6'h3F, 8'hFF);
        check16("R2", sp_out, 16'hAB34);
        rd_check(6'h3F, 8'h00, "R2");

        // R4..R7 normal stepping
        set_sp(16'h0100);
        stack_op(0, "R4"); check16("R4", sp_out, m_sp);
        stack_op(0, "R4"); check16("R4", sp_out, 16'h00FE);
        stack_op(1, "R5"); check16("R5", sp_out, 16'h00FF);
        stack_op(2, "R6"); check16("R6", sp_out, 16'h00FD);
        stack_op(2, "R6"); check16("R6", sp_out, 16'h00FB);
        stack_op(3, "R7"); check16("R7", sp_out, 16'h00FD);
        stack_op(1, "R5"); check16("R5", sp_out, 16'h00FE);
        stack_op(3, "R7"); check16("R7", sp_out, 16'h0100);

        // R9 collisions: write wins, operation dropped
        push_byte = 1'b1;
        io_write(HI, 8'h22);
        push_byte = 1'b0;
        check16("R9", sp_out, 16'h2200);
        pop_ret = 1'b1;
        io_write(LO, 8'h40);
        pop_ret = 1'b0;
        @(negedge clk);
        check16("R9", sp_out, 16'h2240);

        // R10 precedence
        pop_byte = 1'b1;
        stack_op(2, "R10"); check16("R10", sp_out, 16'h223E);
        push_byte = 1'b1;
        stack_op(3, "R10"); check16("R10", sp_out, 16'h2240);
        pop_byte = 1'b1;
        stack_op(0, "R10"); check16("R10", sp_out, 16'h223F);

        // R11 pulses during tail cycles ignored
        push_ret = 1'b1;
        expect_acc(m_sp, "R11");
        expect_acc(m_sp - 16'd1, "R11");
        m_sp = m_sp - 16'd2;
        @(negedge clk);
        push_ret = 1'b0;
        push_byte = 1'b1;
        @(negedge clk);
        push_byte = 1'b0;
        check16("R11", sp_out, 16'h223D);
        pop_ret = 1'b1;
        expect_acc(m_sp + 16'd1, "R11");
        expect_acc(m_sp + 16'd2, "R11");
        m_sp = m_sp + 16'd2;
        @(negedge clk);
        pop_ret = 1'b1;
        @(negedge clk);
        pop_ret = 1'b0;
        check16("R11", sp_out, 16'h223F);

        // R8 wrap-around
        set_sp(16'h0000);
        stack_op(0, "R8"); check16("R8", sp_out, 16'hFFFF);
        stack_op(3, "R8"); check16("R8", sp_out, 16'h0001);
        stack_op(2, "R8"); check16("R8", sp_out, 16'hFFFF);
        stack_op(1, "R8"); check16("R8", sp_out, 16'h0000);

        repeat (2) @(negedge clk);
        check16("R6/R7 pending", 16'(exp_q.size()), 16'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule